// File: doc/BRIEF.md
# Crystal Oscillator Startup Stability Timer

This block decides when a crystal oscillator that has just been enabled, or woken from a paused state, may be treated as settled. While the oscillator is running it counts crystal clock periods. The delay is programmed in coarse units of 256 periods, and a separate control bit can multiply it by four. When the programmed number of periods has passed, the block raises a ready signal in the crystal domain. A copy of that signal, carried through a two-flop synchronizer, is presented in the bus clock domain for software to read.

The oscillator counts as running only while the enable control is high and the pause control is low. When either condition is lost, the ready signal drops in that same moment and the count is discarded. The next enable or wake starts a full new delay. Amplitude detection and clock selection are handled outside this block.

Top module: `xosc_settle_timer`

## Requirements
- R1: During and straight after reset, `osc_ready` and `stable_bus` are both 0.
- R2: With `osc_enable`=1, `dormant`=0 and `delay_x4`=0, `osc_ready` is 0 after N-1 rising `xtal_clk` edges and 1 after the N-th edge, where N = `delay_units` × 256 (e.g. 768 for a value of 3).
- R3: A `delay_units` value of 0 is treated as one unit, giving N = 256, never an immediate ready.
- R4: With `delay_x4`=1, N = `delay_units` × 1024 (delay 0 counts as 1, giving 1024).
- R5: Dropping `osc_enable` clears `osc_ready` at once, before the next crystal edge. A later re-enable waits a full N edges again, including when the drop lands on the edge that would have completed the count.
- R6: `dormant`=1 holds `osc_ready` at 0 even when `osc_enable` is 1. Clearing `dormant` restarts a full N-edge count.
- R7: `stable_bus` follows `osc_ready` through two `bus_clk` flops. It is still 0 when `osc_ready` first rises, and it equals `osc_ready` within three `bus_clk` edges of any change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| xtal_clk | input | 1 | Crystal oscillator clock |
| bus_clk | input | 1 | Bus clock domain |
| osc_enable | input | 1 | Oscillator enabled |
| dormant | input | 1 | Oscillator paused; overrides enable |
| delay_units | input | 14 | Startup delay in units of 256 crystal periods |
| delay_x4 | input | 1 | Multiply the startup delay by four |
| osc_ready | output | 1 | Oscillator settled, crystal domain, gated by run state |
| stable_bus | output | 1 | Settled flag synchronized into the bus domain |

## Verification
Two events can fall in the same crystal cycle: the count reaching its terminal value, and the run condition being withdrawn. The bench brings the count to one edge short of completion and drops the enable before that final edge. It then requires that ready never appears and that a re-enable waits the full delay again. The same check is repeated with the pause control while enable stays high, so that a late completion cannot survive the loss of the run condition.

// File: rtl/xosc_settle_timer.sv
module xosc_settle_timer #(
  parameter int DELAY_W   = 14,
  parameter int UNIT_LOG2 = 8
) (
  input  logic               rst_n,
  input  logic               xtal_clk,
  input  logic               bus_clk,
  input  logic               osc_enable,
  input  logic               dormant,
  input  logic [DELAY_W-1:0] delay_units,
  input  logic               delay_x4,
  output logic               osc_ready,
  output logic               stable_bus
);
  localparam int CNT_W = DELAY_W + UNIT_LOG2 + 2;
  localparam logic [CNT_W-1:0] UNIT = CNT_W'(1) << UNIT_LOG2;

  logic             run;
  logic             done_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] units;
  logic [CNT_W-1:0] target;
  logic             sync1, sync2;

  assign run    = osc_enable && !dormant;
  assign units  = (delay_units == '0) ? CNT_W'(1) : CNT_W'(delay_units);
  assign target = delay_x4 ? (units << (UNIT_LOG2 + 2)) : (units << UNIT_LOG2);

  always_ff @(posedge xtal_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      done_q <= 1'b0;
    end else if (!run) begin
      cnt    <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      cnt <= cnt + 1'b1;
      if (cnt == target - 1'b1) done_q <= 1'b1;
    end
  end

  assign osc_ready = done_q && run;

  always_ff @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
    end else begin
      sync1 <= osc_ready;
      sync2 <= sync1;
    end
  end

  assign stable_bus = sync2;

  assert_rise_needs_run_R2: assert property (@(posedge xtal_clk) disable iff (!rst_n)
    $rose(osc_ready) |-> $past(run));

  assert_min_one_unit_R3: assert property (@(posedge xtal_clk) disable iff (!rst_n)
    osc_ready |-> (cnt >= UNIT));

  assert_disable_clears_R5: assert property (@(posedge xtal_clk) disable iff (!rst_n)
    !osc_enable |=> !osc_ready);

  assert_dormant_holds_R6: assert property (@(posedge xtal_clk) disable iff (!rst_n)
    dormant |=> !osc_ready);
endmodule

// File: tb/xosc_settle_timer_test.sv
module xosc_settle_timer_test;
  logic        rst_n = 1'b0;
  logic        xtal_clk = 1'b0;
  logic        bus_clk = 1'b0;
  logic        osc_enable = 1'b0;
  logic        dormant = 1'b0;
  logic [13:0] delay_units = '0;
  logic        delay_x4 = 1'b0;
  logic        osc_ready;
  logic        stable_bus;

  int checks = 0;
  int fails  = 0;

  always #4 bus_clk = ~bus_clk;
  always #7 xtal_clk = ~xtal_clk;

  xosc_settle_timer uut (
    .rst_n(rst_n), .xtal_clk(xtal_clk), .bus_clk(bus_clk),
    .osc_enable(osc_enable), .dormant(dormant),
    .delay_units(delay_units), .delay_x4(delay_x4),
    .osc_ready(osc_ready), .stable_bus(stable_bus)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic xedges(input int n);
    repeat (n) @(posedge xtal_clk);
    @(negedge xtal_clk);
  endtask

  task automatic bedges(input int n);
    repeat (n) @(posedge bus_clk);
    #1;
  endtask

  task automatic t_reset();
    check("R1 osc_ready", osc_ready, 1'b0);
    check("R1 stable_bus", stable_bus, 1'b0);
    @(negedge xtal_clk);
    rst_n = 1'b1;
    xedges(2);
    check("R1 osc_ready idle", osc_ready, 1'b0);
    check("R1 stable_bus idle", stable_bus, 1'b0);
  endtask

  task automatic t_count(input string req, input logic [13:0] d, input logic x4, input int n);
    delay_units = d;
    delay_x4    = x4;
    osc_enable  = 1'b1;
    xedges(n - 1);
    check({req, " before last edge"}, osc_ready, 1'b0);
    xedges(1);
    check({req, " at N-th edge"}, osc_ready, 1'b1);
    check("R7 stable_bus lags", stable_bus, 1'b0);
    bedges(3);
    check("R7 stable_bus rise", stable_bus, 1'b1);
    @(negedge xtal_clk);
    osc_enable = 1'b0;
    #1;
    check("R5 immediate clear", osc_ready, 1'b0);
    bedges(3);
    check("R7 stable_bus fall", stable_bus, 1'b0);
    @(negedge xtal_clk);
  endtask

  task automatic t_abort_enable();
    delay_units = 14'd1;
    delay_x4    = 1'b0;
    osc_enable  = 1'b1;
    xedges(255);
    osc_enable = 1'b0;
    xedges(1);
    check("R5 abort at terminal edge", osc_ready, 1'b0);
    osc_enable = 1'b1;
    xedges(255);
    check("R5 restart full count", osc_ready, 1'b0);
    xedges(1);
    check("R5 restart completes", osc_ready, 1'b1);
    osc_enable = 1'b0;
    xedges(1);
  endtask

  task automatic t_dormant();
    delay_units = 14'd1;
    delay_x4    = 1'b0;
    osc_enable  = 1'b1;
    dormant     = 1'b1;
    xedges(300);
    check("R6 dormant holds ready low", osc_ready, 1'b0);
    dormant = 1'b0;
    xedges(255);
    check("R6 wake restarts count", osc_ready, 1'b0);
    xedges(1);
    check("R6 wake completes", osc_ready, 1'b1);
    dormant = 1'b1;
    #1;
    check("R6 dormant clears at once", osc_ready, 1'b0);
    xedges(1);
    dormant = 1'b0;
    xedges(255);
    check("R6 abort then full restart", osc_ready, 1'b0);
    xedges(1);
    check("R6 second wake completes", osc_ready, 1'b1);
    osc_enable = 1'b0;
    xedges(1);
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #3;
    t_reset();
    t_count("R2 delay 1", 14'd1, 1'b0, 256);
    t_count("R2 delay 3", 14'd3, 1'b0, 768);
    t_count("R3 delay 0", 14'd0, 1'b0, 256);
    t_count("R4 delay 2 x4", 14'd2, 1'b1, 2048);
    t_count("R4 delay 0 x4", 14'd0, 1'b1, 1024);
    t_abort_enable();
    t_dormant();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule